// File: doc/BRIEF.md
# 16-to-24-bit Word Repacker

This block sits between a 16-bit host data path and a 24-bit word consumer. The host splits two 24-bit words into six bytes and sends them as three 16-bit words, in an order that is not the natural one. The block rebuilds the two 24-bit words from each group of three input words and hands them downstream. Both sides are valid/ready streams. When the output path is wider than 24 bits, the upper bits are filled with zeros.

A two-bit phase counter tracks the position of the next input word within its group. A small byte store keeps the bytes that arrive before their word is complete. A single-entry output register holds each finished word until the consumer takes it. A synchronous clear puts the block back at a group boundary. An end-of-stream marker on an input word ends the current group. Either event in the middle of a group raises a one-cycle error pulse.

Top module: `repack_16to24`

## Requirements
- R1: While reset is held and after it is released, out_valid_o and err_o are 0 and in_ready_o is 1.
- R2: The first word of a group carries byte M0 in bits [15:8] and byte L0 in bits [7:0]. Accepting it produces no output word.
- R3: The second word carries byte L1 in bits [15:8] and byte H0 in bits [7:0]. In the cycle after it is accepted, out_valid_o is 1 and out_data_o[23:0] = {H0, M0, L0}.
- R4: The third word carries byte H1 in bits [15:8] and byte M1 in bits [7:0]. In the cycle after it is accepted, out_valid_o is 1 and out_data_o[23:0] = {H1, M1, L1}.
- R5: The phase advances 0, 1, 2 on each accepted word and returns to 0 after the third. Every group of three accepted words yields exactly two output words.
- R6: Every bit of out_data_o above bit 23 is 0 whenever out_valid_o is 1.
- R7: While out_valid_o is 1 and out_ready_i is 0, in_ready_o is 0 and out_data_o holds its value. A word offered during that time is accepted only once the stall ends.
- R8: A cycle with clear_i high accepts no input (in_ready_o is 0). In the next cycle out_valid_o is 0 and the next accepted word is treated as the first of a group.
- R9: A clear while the phase is not 0 sets err_o to 1 for exactly one cycle, in the cycle after the clear.
- R10: An accepted word with in_last_i high that is not the third of its group sets err_o in the next cycle and returns the phase to 0. A marked third word raises no error.
- R11: A clear while the phase is 0 leaves err_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous return to a group boundary |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 16 | Input word |
| in_last_i | input | 1 | Marks the final word of the stream |
| in_ready_o | output | 1 | Block can accept an input word |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | OUT_W (32) | Rebuilt 24-bit word, zero filled above |
| out_ready_i | input | 1 | Consumer accepts the output word |
| err_o | output | 1 | One-cycle pulse on a clear or stream end in mid-group |

## Verification
The assertions check the following on every cycle:
- The phase wraps back to 0 after a third word.
- Output data stays stable and input is refused during a stall.
- The upper bits stay zero.
- A clear empties the output.
- The error pulse follows a mid-group clear or stream end, and a boundary clear raises none.

Only the bench's scenarios can show that the bytes land in the right positions. The bench covers byte placement across several patterns and recovery after a clear or an early stream end. It also checks that a word offered during a stall arrives intact once the stall is released.

// File: rtl/repack_pkg.sv
package repack_pkg;
  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_C = 2'd2
  } phase_e;
endpackage

// File: rtl/repack_phase.sv
module repack_phase
  import repack_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clear_i,
  input  logic   acc_i,
  input  logic   last_i,
  output phase_e phase_o,
  output logic   err_o
);
  phase_e phase_q, phase_d;
  logic   err_d;

  always_comb begin
    phase_d = phase_q;
    if (clear_i) begin
      phase_d = PH_A;
    end else if (acc_i) begin
      if (last_i) begin
        phase_d = PH_A;
      end else begin
        unique case (phase_q)
          PH_A:    phase_d = PH_B;
          PH_B:    phase_d = PH_C;
          default: phase_d = PH_A;
        endcase
      end
    end
  end

  // mid-group clear, or early end of stream
  assign err_d = (clear_i && phase_q != PH_A) ||
                 (!clear_i && acc_i && last_i && phase_q != PH_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_A;
      err_o   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      err_o   <= err_d;
    end
  end

  assign phase_o = phase_q;

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !clear_i && phase_q == PH_C) |=> phase_q == PH_A);

  p_clear_phase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> phase_q == PH_A);

  p_err_mid_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && phase_q != PH_A) |=> err_o);

  p_no_err_edge_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && phase_q == PH_A) |=> !err_o);

  p_early_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && last_i && !clear_i && phase_q != PH_C) |=> (err_o && phase_q == PH_A));
endmodule

// File: rtl/repack_hold.sv
module repack_hold
  import repack_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned IN_W   = 2 * BYTE_W,
  localparam int unsigned WORD_W = 3 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              acc_i,
  input  phase_e            phase_i,
  input  logic [IN_W-1:0]   data_i,
  output logic              load_o,
  output logic [WORD_W-1:0] word_o
);
  logic [BYTE_W-1:0] hi_b, lo_b;
  logic [BYTE_W-1:0] m0_q, l0_q, l1_q;

  assign hi_b = data_i[IN_W-1:BYTE_W];
  assign lo_b = data_i[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m0_q <= '0;
      l0_q <= '0;
      l1_q <= '0;
    end else if (clear_i) begin
      m0_q <= '0;
      l0_q <= '0;
      l1_q <= '0;
    end else if (acc_i) begin
      if (phase_i == PH_A) begin
        m0_q <= hi_b;
        l0_q <= lo_b;
      end
      if (phase_i == PH_B) begin
        l1_q <= hi_b;
      end
    end
  end

  assign load_o = acc_i && !clear_i && (phase_i != PH_A);
  // phase B: {H0,M0,L0}; phase C: {H1,M1,L1}
  assign word_o = (phase_i == PH_B) ? {lo_b, m0_q, l0_q} : {hi_b, lo_b, l1_q};

  p_hold_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !(acc_i && phase_i == PH_A)) |=> ($stable(m0_q) && $stable(l0_q)));
endmodule

// File: rtl/repack_outreg.sv
module repack_outreg #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned OUT_W  = 32,
  localparam int unsigned FILL_W = OUT_W - WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  data_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_q  <= '0;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      word_q  <= word_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  generate
    if (FILL_W > 0) begin : g_fill
      assign data_o = {{FILL_W{1'b0}}, word_q};

      p_zero_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (data_o[OUT_W-1:WORD_W] == '0));
    end else begin : g_exact
      assign data_o = word_q;
    end
  endgenerate

  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !clear_i) |=> (valid_o && $stable(data_o)));

  p_clear_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !valid_o);
endmodule

// File: rtl/repack_16to24.sv
module repack_16to24
  import repack_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned OUT_W  = 32,
  localparam int unsigned IN_W   = 2 * BYTE_W,
  localparam int unsigned WORD_W = 3 * BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             in_valid_i,
  input  logic [IN_W-1:0]  in_data_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_data_o,
  input  logic             out_ready_i,
  output logic             err_o
);
  phase_e            phase;
  logic              acc;
  logic              load;
  logic [WORD_W-1:0] word;

  assign in_ready_o = !clear_i && !(out_valid_o && !out_ready_i);
  assign acc        = in_valid_i && in_ready_o;

  repack_phase i_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .acc_i   (acc),
    .last_i  (in_last_i),
    .phase_o (phase),
    .err_o   (err_o)
  );

  repack_hold #(.BYTE_W(BYTE_W)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .acc_i   (acc),
    .phase_i (phase),
    .data_i  (in_data_i),
    .load_o  (load),
    .word_o  (word)
  );

  repack_outreg #(.WORD_W(WORD_W), .OUT_W(OUT_W)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .load_i  (load),
    .word_i  (word),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .data_o  (out_data_o)
  );

  p_stall_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  p_out_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(acc && !clear_i && phase != PH_A));
endmodule

// File: tb/test_repack_16to24.sv
module test_repack_16to24;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b1;
  logic        err;

  int checks = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  repack_16to24 i_repack_16to24 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .clear_i     (clear),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .in_last_i   (in_last),
    .in_ready_o  (in_ready),
    .out_valid_o (out_valid),
    .out_data_o  (out_data),
    .out_ready_i (out_ready),
    .err_o       (err)
  );

  // each entry: {H0,M0,L0,H1,M1,L1}
  localparam logic [47:0] VEC [4] = '{
    48'h123456_ABCDEF,
    48'h000000_FFFFFF,
    48'hFF00FF_00FF00,
    48'hA5C33C_5AE781
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one word at a negedge, accept at the posedge, sample at the next negedge
  task automatic send(input logic [15:0] w, input logic last);
    in_valid = 1'b1;
    in_data  = w;
    in_last  = last;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  h0, m0, l0, h1, m1, l1;
    logic [31:0] o1, o2, held;

    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0 && err == 1'b0, "R1 in reset", {30'b0, out_valid, err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && err == 1'b0, "R1 after reset",
        {29'b0, in_ready, out_valid, err}, 32'h4);

    for (int i = 0; i < 4; i++) begin
      {h0, m0, l0, h1, m1, l1} = VEC[i];
      o1 = {8'h00, h0, m0, l0};
      o2 = {8'h00, h1, m1, l1};
      send({m0, l0}, 1'b0);
      chk(out_valid == 1'b0, "R2 no output after first word", {31'b0, out_valid}, 32'h0);
      send({l1, h0}, 1'b0);
      chk(out_valid == 1'b1 && out_data == o1, "R3 first word", out_data, o1);
      chk(out_data[31:24] == 8'h00, "R6 zero fill", {24'b0, out_data[31:24]}, 32'h0);
      send({h1, m1}, i == 3);
      chk(out_valid == 1'b1 && out_data == o2, "R4 second word", out_data, o2);
      chk(err == 1'b0, "R10 marked third word raises no error", {31'b0, err}, 32'h0);
      @(negedge clk);
      chk(out_valid == 1'b0, "R5 two outputs per group", {31'b0, out_valid}, 32'h0);
    end

    // R7: stall
    out_ready = 1'b0;
    send(16'h2211, 1'b0);
    send(16'h4433, 1'b0);
    chk(out_valid == 1'b1 && out_data == 32'h00332211, "R3 under stall", out_data, 32'h00332211);
    held = out_data;
    in_valid = 1'b1;
    in_data  = 16'h6655;
    #1;
    chk(in_ready == 1'b0, "R7 ready low in stall", {31'b0, in_ready}, 32'h0);
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b1 && out_data == held, "R7 data held", out_data, held);
    chk(in_ready == 1'b0, "R7 ready still low", {31'b0, in_ready}, 32'h0);
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R7 ready on release", {31'b0, in_ready}, 32'h1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1 && out_data == 32'h00665544, "R7 R4 word after stall", out_data, 32'h00665544);
    @(negedge clk);

    // R9: clear mid-group
    send(16'hAABB, 1'b0);
    clear = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R8 no accept during clear", {31'b0, in_ready}, 32'h0);
    @(negedge clk);
    clear = 1'b0;
    chk(err == 1'b1, "R9 error after mid clear", {31'b0, err}, 32'h1);
    @(negedge clk);
    chk(err == 1'b0, "R9 error lasts one cycle", {31'b0, err}, 32'h0);
    send(16'h0201, 1'b0);
    send(16'h0403, 1'b0);
    chk(out_valid == 1'b1 && out_data == 32'h00030201, "R8 resync after clear", out_data, 32'h00030201);
    send(16'h0605, 1'b0);
    chk(out_data == 32'h00060504, "R8 resync second word", out_data, 32'h00060504);
    @(negedge clk);

    // R11: clear at a group boundary
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(err == 1'b0, "R11 no error at boundary clear", {31'b0, err}, 32'h0);

    // R8: clear drops a pending word
    out_ready = 1'b0;
    send(16'h1122, 1'b0);
    send(16'h3344, 1'b0);
    chk(out_valid == 1'b1, "R8 word pending", {31'b0, out_valid}, 32'h1);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    out_ready = 1'b1;
    chk(out_valid == 1'b0, "R8 clear empties output", {31'b0, out_valid}, 32'h0);
    chk(err == 1'b1, "R9 clear at phase 2", {31'b0, err}, 32'h1);
    @(negedge clk);

    // R10: early end of stream
    send(16'h7788, 1'b1);
    chk(err == 1'b1, "R10 error on early last", {31'b0, err}, 32'h1);
    chk(out_valid == 1'b0, "R10 no output after early last", {31'b0, out_valid}, 32'h0);
    send(16'h0B0C, 1'b0);
    send(16'h0E0A, 1'b0);
    chk(out_data == 32'h000A0B0C && err == 1'b0, "R10 resync after early last", out_data, 32'h000A0B0C);
    send(16'h0F0D, 1'b0);
    chk(out_data == 32'h000F0D0E, "R10 resync second word", out_data, 32'h000F0D0E);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule